// File: doc/BRIEF.md
# Call and Return Address Stack

This block holds program-counter values for subroutine calls and interrupt entries in a small dedicated store, separate from program and data space. The instruction sequencer raises a push strobe with the current program counter when a call or an interrupt is taken. It raises a pop strobe on a return, and the block then hands back the saved address. A pointer counts the valid entries. The value 0 means empty and has no entry behind it, so up to 31 addresses of 21 bits can be held.

Software reaches the block through a four-location byte register port. One location holds the pointer and two sticky status flags: stack full and stack underflow. The other three hold the upper, high and low bytes of the entry the pointer currently selects, so a routine can spill and refill the stack from its own memory. A static configuration input picks what an overflow or underflow does. When it is clear, the stack saturates and reports. When it is set, the block also requests a device reset. Two reset inputs are provided. The power-on reset clears the sticky flags; the general reset does not.

Top module: `call_ret_stack`

## Requirements
- R1: `por` clears the pointer, both flags, `ret_pc_o`, `reg_rdata_o` and `rst_req_o` at the next edge. `rst` clears the pointer, `ret_pc_o`, `reg_rdata_o` and `rst_req_o` but leaves both flags unchanged. `por` wins over `rst`.
- R2: An accepted push with the pointer below 31 first increments the pointer, then stores `pc_i` in the entry the new pointer names.
- R3: An accepted pop with the pointer above 0 puts the selected entry on `ret_pc_o` at the next edge and decrements the pointer. `ret_pc_o` holds its value when no pop is accepted.
- R4: A push that moves the pointer from 30 to 31 sets the full flag.
- R5: A push with the pointer at 31 stores nothing, leaves the pointer at 31 and sets the full flag.
- R6: With `ovf_rst_en` high, a push at pointer 31 drives `rst_req_o` high for exactly the following cycle. `rst_req_o` is never high unless `ovf_rst_en` was high on the previous edge.
- R7: A pop with the pointer at 0 returns zero on `ret_pc_o`, sets the underflow flag and leaves the pointer at 0. With `ovf_rst_en` low it raises no reset request.
- R8: With `ovf_rst_en` high, a pop at pointer 0 also sets the full flag and drives `rst_req_o` high for one cycle.
- R9: The full and underflow flags are sticky. Only `por` or a software write to the pointer register changes them.
- R10: Register map on `reg_sel_i`. Select 0 is the pointer register: bit 7 full, bit 6 underflow, bit 5 zero, bits 4:0 pointer. A write loads all three fields. Select 1 is entry bits 7:0, select 2 is bits 15:8, and select 3 is bits 20:16 in its bits 4:0. A write to select 3 stores only `reg_wdata_i[4:0]`. `reg_rdata_o` shows, one edge later, the selected byte of the state held before that edge. Entry bytes read 0 and ignore writes while the pointer is 0.
- R11: Priority in one cycle: push over pop, and pop over register write. The strobe that loses is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| rst | input | 1 | General reset, synchronous, active high |
| ovf_rst_en | input | 1 | Static: overflow and underflow request a device reset |
| push_i | input | 1 | Push strobe from the sequencer |
| pc_i | input | 21 | Program counter to save on push |
| pop_i | input | 1 | Pop strobe from the sequencer |
| ret_pc_o | output | 21 | Return address, registered |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select (0 pointer, 1 low, 2 high, 3 upper) |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, registered |
| rst_req_o | output | 1 | One-cycle device-reset request |

## Verification
A wrong pointer shows up at the ports one edge later: the pointer register reads back wrong, and the entry bytes at select 1 to 3 read a neighbouring entry. A lost or misplaced store usually stays hidden until the matching pop, which may come many cycles later, so the bench compares the top-entry bytes after every push and partial write. A flag that is not sticky across the general reset can only be seen by reading the pointer register after that reset. A missing or stretched reset request is visible on the cycle right after the offending strobe.

// File: rtl/rstk_pkg.sv
package rstk_pkg;
  localparam int unsigned PC_W_DEF  = 21;
  localparam int unsigned PTR_W_DEF = 5;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned FULL_BIT  = 7;
  localparam int unsigned UNF_BIT   = 6;

  typedef enum logic [1:0] {
    SEL_PTR  = 2'd0,
    SEL_TOSL = 2'd1,
    SEL_TOSH = 2'd2,
    SEL_TOSU = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/rstk_mem.sv
module rstk_mem #(
  parameter int unsigned PC_W  = rstk_pkg::PC_W_DEF,
  parameter int unsigned PTR_W = rstk_pkg::PTR_W_DEF
) (
  input  logic             clk,
  input  logic             we,
  input  logic [PTR_W-1:0] waddr,
  input  logic [PC_W-1:0]  wdata,
  input  logic [PTR_W-1:0] raddr,
  output logic [PC_W-1:0]  rdata
);
  localparam int unsigned DEPTH = (1 << PTR_W) - 1;

  // address 0 is the empty marker and has no row
  logic [PC_W-1:0] store [1:DEPTH];

  always_ff @(posedge clk) begin
    if (we && waddr != '0) store[waddr] <= wdata;
  end

  assign rdata = (raddr == '0) ? '0 : store[raddr];
endmodule

// File: rtl/rstk_ctrl.sv
module rstk_ctrl #(
  parameter int unsigned PC_W  = rstk_pkg::PC_W_DEF,
  parameter int unsigned PTR_W = rstk_pkg::PTR_W_DEF
) (
  input  logic             clk,
  input  logic             por,
  input  logic             rst,
  input  logic             ovf_rst_en,
  input  logic             push,
  input  logic             pop,
  input  logic [PC_W-1:0]  pc,
  input  logic             wr,
  input  logic [1:0]       sel,
  input  logic [7:0]       wdata,
  input  logic [PC_W-1:0]  tos,
  output logic [PTR_W-1:0] ptr,
  output logic             full,
  output logic             unf,
  output logic             rst_req,
  output logic             pop_take,
  output logic             mem_we,
  output logic [PTR_W-1:0] mem_waddr,
  output logic [PC_W-1:0]  mem_wdata
);
  import rstk_pkg::*;

  localparam int unsigned     UP_W     = PC_W - 16;
  localparam logic [PTR_W-1:0] TOP_IDX  = '1;
  localparam logic [PTR_W-1:0] NEAR_TOP = TOP_IDX - 1'b1;

  reg_sel_e        sel_e;
  logic            at_top, at_base, do_wr, wr_ptr_reg, wr_tos;
  logic [PC_W-1:0] tos_merge;

  assign sel_e      = reg_sel_e'(sel);
  assign at_top     = (ptr == TOP_IDX);
  assign at_base    = (ptr == '0);
  assign pop_take   = pop && !push;
  assign do_wr      = wr && !push && !pop;
  assign wr_ptr_reg = do_wr && (sel_e == SEL_PTR);
  assign wr_tos     = do_wr && (sel_e != SEL_PTR) && !at_base;

  always_comb begin
    tos_merge = tos;
    unique case (sel_e)
      SEL_TOSL: tos_merge[7:0]       = wdata;
      SEL_TOSH: tos_merge[15:8]      = wdata;
      SEL_TOSU: tos_merge[PC_W-1:16] = wdata[UP_W-1:0];
      default:  tos_merge            = tos;
    endcase
  end

  assign mem_we    = (push && !at_top) || wr_tos;
  assign mem_waddr = push ? ptr + 1'b1 : ptr;
  assign mem_wdata = push ? pc : tos_merge;

  always_ff @(posedge clk) begin
    if (por) begin
      ptr     <= '0;
      full    <= 1'b0;
      unf     <= 1'b0;
      rst_req <= 1'b0;
    end else if (rst) begin
      ptr     <= '0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= 1'b0;
      if (push) begin
        if (!at_top) begin
          ptr <= ptr + 1'b1;
          if (ptr == NEAR_TOP) full <= 1'b1;
        end else begin
          full    <= 1'b1;
          rst_req <= ovf_rst_en;
        end
      end else if (pop) begin
        if (at_base) begin
          unf <= 1'b1;
          if (ovf_rst_en) begin
            full    <= 1'b1;
            rst_req <= 1'b1;
          end
        end else begin
          ptr <= ptr - 1'b1;
        end
      end else if (wr_ptr_reg) begin
        ptr  <= wdata[PTR_W-1:0];
        full <= wdata[FULL_BIT];
        unf  <= wdata[UNF_BIT];
      end
    end
  end

  // R2
  push_inc_chk: assert property (@(posedge clk) disable iff (por || rst)
    (push && !at_top) |=> (ptr == $past(ptr) + 1'b1));

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (por || rst)
    (push && at_top) |=> (ptr == TOP_IDX && full));

  // R7
  underflow_hold_chk: assert property (@(posedge clk) disable iff (por || rst)
    (pop_take && at_base) |=> (ptr == '0 && unf));

  // R6
  req_source_chk: assert property (@(posedge clk) disable iff (por || rst)
    rst_req |-> $past(ovf_rst_en));

  // R9
  full_sticky_chk: assert property (@(posedge clk) disable iff (por)
    (full && !wr_ptr_reg) |=> full);

  // R9
  unf_sticky_chk: assert property (@(posedge clk) disable iff (por)
    (unf && !wr_ptr_reg) |=> unf);
endmodule

// File: rtl/rstk_regif.sv
module rstk_regif #(
  parameter int unsigned PC_W  = rstk_pkg::PC_W_DEF,
  parameter int unsigned PTR_W = rstk_pkg::PTR_W_DEF
) (
  input  logic             clk,
  input  logic             por,
  input  logic             rst,
  input  logic [1:0]       sel,
  input  logic [PTR_W-1:0] ptr,
  input  logic             full,
  input  logic             unf,
  input  logic [PC_W-1:0]  tos,
  input  logic             pop_take,
  output logic [PC_W-1:0]  ret_pc,
  output logic [7:0]       rdata
);
  import rstk_pkg::*;

  localparam int unsigned UP_W = PC_W - 16;
  localparam int unsigned PAD  = BYTE_W - 2 - PTR_W;

  reg_sel_e   sel_e;
  logic [7:0] rd_next;

  assign sel_e = reg_sel_e'(sel);

  always_comb begin
    unique case (sel_e)
      SEL_PTR:  rd_next = {full, unf, {PAD{1'b0}}, ptr};
      SEL_TOSL: rd_next = tos[7:0];
      SEL_TOSH: rd_next = tos[15:8];
      SEL_TOSU: rd_next = {{(BYTE_W-UP_W){1'b0}}, tos[PC_W-1:16]};
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (por || rst) begin
      ret_pc <= '0;
      rdata  <= '0;
    end else begin
      rdata <= rd_next;
      if (pop_take) ret_pc <= tos;
    end
  end

  // R7
  empty_ret_chk: assert property (@(posedge clk) disable iff (por || rst)
    (pop_take && ptr == '0) |=> (ret_pc == '0));

  // R3
  ret_hold_chk: assert property (@(posedge clk) disable iff (por || rst)
    !pop_take |=> $stable(ret_pc));
endmodule

// File: rtl/call_ret_stack.sv
module call_ret_stack #(
  parameter int unsigned PC_W  = rstk_pkg::PC_W_DEF,
  parameter int unsigned PTR_W = rstk_pkg::PTR_W_DEF
) (
  input  logic            clk,
  input  logic            por,
  input  logic            rst,
  input  logic            ovf_rst_en,
  input  logic            push_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic            pop_i,
  output logic [PC_W-1:0] ret_pc_o,
  input  logic            reg_wr_i,
  input  logic [1:0]      reg_sel_i,
  input  logic [7:0]      reg_wdata_i,
  output logic [7:0]      reg_rdata_o,
  output logic            rst_req_o
);
  logic [PTR_W-1:0] ptr, mem_waddr;
  logic             full, unf, pop_take, mem_we;
  logic [PC_W-1:0]  tos, mem_wdata;

  rstk_mem #(.PC_W(PC_W), .PTR_W(PTR_W)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (ptr),
    .rdata (tos)
  );

  rstk_ctrl #(.PC_W(PC_W), .PTR_W(PTR_W)) u_ctrl (
    .clk        (clk),
    .por        (por),
    .rst        (rst),
    .ovf_rst_en (ovf_rst_en),
    .push       (push_i),
    .pop        (pop_i),
    .pc         (pc_i),
    .wr         (reg_wr_i),
    .sel        (reg_sel_i),
    .wdata      (reg_wdata_i),
    .tos        (tos),
    .ptr        (ptr),
    .full       (full),
    .unf        (unf),
    .rst_req    (rst_req_o),
    .pop_take   (pop_take),
    .mem_we     (mem_we),
    .mem_waddr  (mem_waddr),
    .mem_wdata  (mem_wdata)
  );

  rstk_regif #(.PC_W(PC_W), .PTR_W(PTR_W)) u_regif (
    .clk      (clk),
    .por      (por),
    .rst      (rst),
    .sel      (reg_sel_i),
    .ptr      (ptr),
    .full     (full),
    .unf      (unf),
    .tos      (tos),
    .pop_take (pop_take),
    .ret_pc   (ret_pc_o),
    .rdata    (reg_rdata_o)
  );

  // R1
  por_clear_chk: assert property (@(posedge clk)
    $past(por) |-> (reg_rdata_o == 8'h00 && ret_pc_o == '0 && !rst_req_o));
endmodule

// File: tb/tb_call_ret_stack.sv
module tb_call_ret_stack;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        por = 1'b1, rst = 1'b0, en = 1'b0;
  logic        push_i = 1'b0, pop_i = 1'b0, reg_wr_i = 1'b0;
  logic [20:0] pc_i = '0;
  logic [1:0]  reg_sel_i = '0;
  logic [7:0]  reg_wdata_i = '0;
  logic [20:0] ret_pc_o;
  logic [7:0]  reg_rdata_o;
  logic        rst_req_o;

  int checks = 0, fails = 0, cycles = 0;

  // behavioural reference
  logic [20:0] m_mem [0:31];
  int          m_ptr = 0;
  logic        m_full = 0, m_unf = 0, m_req = 0;
  logic [20:0] m_ret = '0;
  logic [7:0]  m_rd = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  call_ret_stack dut (
    .clk(clk), .por(por), .rst(rst), .ovf_rst_en(en),
    .push_i(push_i), .pc_i(pc_i), .pop_i(pop_i), .ret_pc_o(ret_pc_o),
    .reg_wr_i(reg_wr_i), .reg_sel_i(reg_sel_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .rst_req_o(rst_req_o)
  );

  function automatic logic [20:0] val(input int i);
    logic [31:0] t;
    t = (i * 32'h9E37 + 32'h15A3) ^ (i << 13);
    return t[20:0];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    logic [20:0] t;
    t = (m_ptr == 0) ? 21'd0 : m_mem[m_ptr];
    if (por) begin
      m_ptr = 0; m_full = 0; m_unf = 0; m_req = 0; m_ret = '0; m_rd = '0;
    end else if (rst) begin
      m_ptr = 0; m_req = 0; m_ret = '0; m_rd = '0;
    end else begin
      case (reg_sel_i)
        2'd0: m_rd = {m_full, m_unf, 1'b0, 5'(m_ptr)};
        2'd1: m_rd = t[7:0];
        2'd2: m_rd = t[15:8];
        default: m_rd = {3'b000, t[20:16]};
      endcase
      m_req = 0;
      if (push_i) begin
        if (m_ptr < 31) begin
          m_ptr++;
          m_mem[m_ptr] = pc_i;
          if (m_ptr == 31) m_full = 1;
        end else begin
          m_full = 1;
          m_req = en;
        end
      end else if (pop_i) begin
        if (m_ptr == 0) begin
          m_ret = '0; m_unf = 1;
          if (en) begin m_full = 1; m_req = 1; end
        end else begin
          m_ret = m_mem[m_ptr];
          m_ptr--;
        end
      end else if (reg_wr_i) begin
        if (reg_sel_i == 2'd0) begin
          m_ptr = int'(reg_wdata_i[4:0]);
          m_full = reg_wdata_i[7];
          m_unf = reg_wdata_i[6];
        end else if (m_ptr != 0) begin
          if (reg_sel_i == 2'd1) m_mem[m_ptr][7:0] = reg_wdata_i;
          else if (reg_sel_i == 2'd2) m_mem[m_ptr][15:8] = reg_wdata_i;
          else m_mem[m_ptr][20:16] = reg_wdata_i[4:0];
        end
      end
    end
  endtask

  task automatic step(input bit pu, input bit pp, input bit wr,
                      input logic [1:0] sel, input logic [7:0] wd, input logic [20:0] pc);
    @(negedge clk);
    push_i = pu; pop_i = pp; reg_wr_i = wr;
    reg_sel_i = sel; reg_wdata_i = wd; pc_i = pc;
    @(posedge clk);
    model_edge();
    #1;
    chk("R10 rdata", reg_rdata_o, m_rd);
    chk("R3 ret_pc", ret_pc_o, m_ret);
    chk("R6 rst_req", rst_req_o, m_req);
  endtask

  task automatic idle(input logic [1:0] sel);
    step(0, 0, 0, sel, 8'h00, '0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    // R1 power-on state
    repeat (3) idle(0);
    por = 0;
    idle(0);
    chk("R1 ptr reg after por", reg_rdata_o, 8'h00);
    chk("R1 ret after por", ret_pc_o, 0);
    chk("R1 req after por", rst_req_o, 0);

    // R2 pushes store at new pointer
    for (int i = 1; i <= 5; i++) step(1, 0, 0, 0, 0, val(i));
    idle(3); chk("R2 tos upper", reg_rdata_o, {3'b0, val(5)[20:16]});
    idle(2); chk("R2 tos high", reg_rdata_o, val(5)[15:8]);
    idle(1); chk("R2 tos low", reg_rdata_o, val(5)[7:0]);
    idle(0); chk("R2 ptr", reg_rdata_o, 8'h05);

    // R3 pops
    step(0, 1, 0, 0, 0, 0); chk("R3 pop1", ret_pc_o, val(5));
    step(0, 1, 0, 0, 0, 0); chk("R3 pop2", ret_pc_o, val(4));
    idle(0); chk("R3 ptr after pops", reg_rdata_o, 8'h03);

    // R11 push beats pop, pop beats write
    step(1, 1, 0, 0, 0, val(100));
    chk("R11 ret unchanged", ret_pc_o, val(4));
    idle(0); chk("R11 ptr after push+pop", reg_rdata_o, 8'h04);
    idle(1); chk("R11 pushed value", reg_rdata_o, val(100)[7:0]);
    step(0, 1, 1, 0, 8'h1F, 0);
    idle(0); chk("R11 write lost to pop", reg_rdata_o, 8'h03);

    // R4 fill to 31
    for (int i = 0; i < 27; i++) step(1, 0, 0, 0, 0, val(10 + i));
    idle(0); chk("R4 ptr 30 not full", reg_rdata_o, 8'h1E);
    step(1, 0, 0, 0, 0, val(77));
    idle(0); chk("R4 full at 31", reg_rdata_o, 8'h9F);

    // R5 overflow with enable clear
    step(1, 0, 0, 0, 0, val(200));
    chk("R5 no request", rst_req_o, 0);
    idle(0); chk("R5 ptr stays", reg_rdata_o, 8'h9F);
    idle(1); chk("R5 data kept", reg_rdata_o, val(77)[7:0]);

    // R10 byte writes
    step(0, 0, 1, 3, 8'hFF, 0);
    idle(3); chk("R10 upper low 5 bits", reg_rdata_o, 8'h1F);
    step(0, 0, 1, 1, 8'hA5, 0);
    idle(1); chk("R10 low write", reg_rdata_o, 8'hA5);
    idle(2); chk("R10 high untouched", reg_rdata_o, val(77)[15:8]);

    // R9 software write clears flags
    step(0, 0, 1, 0, 8'h03, 0);
    idle(0); chk("R9 sw clear", reg_rdata_o, 8'h03);

    // R7 underflow with enable clear
    repeat (3) step(0, 1, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0);
    chk("R7 ret zero", ret_pc_o, 0);
    chk("R7 no request", rst_req_o, 0);
    idle(0); chk("R7 unf set ptr 0", reg_rdata_o, 8'h40);
    step(0, 0, 1, 2, 8'h55, 0);
    idle(2); chk("R10 entry at 0 reads 0", reg_rdata_o, 8'h00);

    // R1 general reset keeps flags
    rst = 1; idle(0); rst = 0;
    idle(0); chk("R1 rst keeps flags", reg_rdata_o, 8'h40);

    // R8 underflow with enable set
    en = 1;
    step(0, 1, 0, 0, 0, 0);
    chk("R8 request", rst_req_o, 1);
    idle(0); chk("R8 full and unf", reg_rdata_o, 8'hC0);
    chk("R6 pulse one cycle", rst_req_o, 0);
    rst = 1; idle(0); rst = 0;

    // R6 overflow with enable set
    step(0, 0, 1, 0, 8'h1E, 0);
    step(1, 0, 0, 0, 0, val(300));
    idle(0); chk("R4 full again", reg_rdata_o, 8'h9F);
    step(1, 0, 0, 0, 0, val(301));
    chk("R6 overflow request", rst_req_o, 1);
    idle(1); chk("R5 data kept en set", reg_rdata_o, val(300)[7:0]);
    rst = 1; idle(0); rst = 0;
    idle(0); chk("R1 rst ptr 0 full kept", reg_rdata_o, 8'h80);

    // R9 only por clears sticky flags
    por = 1; idle(0); por = 0;
    idle(0); chk("R9 por clears flags", reg_rdata_o, 8'h00);

    finish_run();
  end
endmodule